// File: doc/BRIEF.md
# Unary Bit-Stream Sorting Network

This block sorts eight small unsigned integers. It does this by turning each one into a unary bit-stream and passing all eight streams together through a fixed compare-and-swap network. A start pulse captures the eight binary inputs. A shared index then steps through the stream positions. At each position, every lane emits a 1 while the index is below that lane's value, and a 0 after that. So a value v becomes v ones followed by zeros, in a stream whose length is two to the power of the value width.

Each compare-and-swap cell is one AND gate, which yields the smaller stream, and one OR gate, which yields the larger. There is no magnitude comparator and no multiplexer. The cells form a bitonic arrangement whose pairings are fixed at elaboration, so the order of comparisons never depends on the data. One counter per output lane adds up the ones that leave the network. After the final stream bit, the counters hold the sorted values in binary and a one-cycle done flag is raised.

The block is used as a latency-tolerant sorter. A sort costs a fixed number of cycles set by the value width, whatever the data are.

Top module: `usort_top`

## Requirements
- R1: An input of value v is encoded as a stream of length 2^VAL_W in which position k is 1 exactly when k < v. While a sort is in progress, the count on an output lane therefore grows by at most one per cycle.
- R2: Each compare-and-swap cell puts the AND of its two input bits on its lower lane and the OR on its upper lane, for ascending pairs. Descending pairs swap these. At every stream position, the network output bits are ordered so that a 1 on lane i implies a 1 on lane i+1.
- R3: The network consists of log2(8)·(log2(8)+1)/2 = 6 stages of 4 cells each, wired in bitonic order. After a sort, out_vals[0] holds the smallest input and out_vals[7] the largest, in ascending order.
- R4: Repeated values, the value 0 and the value 2^VAL_W−1 are all sorted exactly.
- R5: done is high for exactly one cycle. It is raised 2^VAL_W clock edges after the edge that accepts start.
- R6: A start pulse that arrives while a sort is in progress is ignored. Input changes during a sort have no effect on its results or on its done timing, and no second done follows.
- R7: After reset, every output value is 0 and done is 0. While no sort is running, the output values hold until the next accepted start, which clears them to 0.
- R8: In every cycle of a sort, the network emits as many 1 bits as the encoder feeds it. The sum of the results therefore equals the sum of the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to capture in_vals and begin a sort |
| in_vals | input | 8×VAL_W | Eight unsigned values to sort, lane-indexed |
| out_vals | output | 8×VAL_W | Sorted results, lane 0 smallest |
| done | output | 1 | One-cycle pulse when out_vals holds a finished sort |

## Verification
The hardest situation to reach from the ports is a start request that lands in the middle of a running sort with different inputs on the bus. This is what shows that the captured values stay put and that the done timing does not move. The stimulus starts a sort and, a few cycles later, presents new values with a second start pulse. It also issues a start on the very cycle that done is high, which tests the boundary between the busy and idle phases. A behavioural model predicts each lane's running count as the smaller of its sorted target and the elapsed stream position. This exposes order and encoding faults at every cycle, not only at the end.

// File: rtl/usort_pkg.sv
package usort_pkg;

  // number of bitonic stages for 2**log_lanes lanes
  function automatic int stage_total(input int log_lanes);
    return (log_lanes * (log_lanes + 1)) / 2;
  endfunction

  // block size (k) used by a given stage index
  function automatic int stage_block(input int log_lanes, input int s);
    int n;
    n = 0;
    for (int p = 1; p <= log_lanes; p++) begin
      for (int q = p - 1; q >= 0; q--) begin
        if (n == s) return (1 << p);
        n++;
      end
    end
    return 2;
  endfunction

  // partner distance (j) used by a given stage index
  function automatic int stage_dist(input int log_lanes, input int s);
    int n;
    n = 0;
    for (int p = 1; p <= log_lanes; p++) begin
      for (int q = p - 1; q >= 0; q--) begin
        if (n == s) return (1 << q);
        n++;
      end
    end
    return 1;
  endfunction

  // lower lane of the c-th cell in a stage with distance j
  function automatic int cell_low_lane(input int j, input int c);
    return ((c / j) * 2 * j) + (c % j);
  endfunction

endpackage

// File: rtl/usort_cas.sv
module usort_cas (
  input  logic a_bit,
  input  logic b_bit,
  output logic lo_bit,
  output logic hi_bit
);
  assign lo_bit = a_bit & b_bit;
  assign hi_bit = a_bit | b_bit;
endmodule

// File: rtl/usort_encoder.sv
module usort_encoder #(
  parameter int VAL_W = 4,
  parameter int LANES = 8
) (
  input  logic [LANES-1:0][VAL_W-1:0] vals,
  input  logic [VAL_W-1:0]            idx,
  output logic [LANES-1:0]            bits
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign bits[l] = (idx < vals[l]);
  end
endmodule

// File: rtl/usort_net.sv
module usort_net #(
  parameter int LOG_LANES = 3
) (
  input  logic [(1<<LOG_LANES)-1:0] in_bits,
  output logic [(1<<LOG_LANES)-1:0] out_bits
);
  import usort_pkg::*;

  localparam int LANES  = 1 << LOG_LANES;
  localparam int CELLS  = LANES / 2;
  localparam int STAGES = stage_total(LOG_LANES);

  logic [STAGES:0][LANES-1:0] wire_q;

  assign wire_q[0] = in_bits;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    localparam int K = stage_block(LOG_LANES, s);
    localparam int J = stage_dist(LOG_LANES, s);
    for (genvar c = 0; c < CELLS; c++) begin : g_cell
      localparam int LO  = cell_low_lane(J, c);
      localparam int HI  = LO + J;
      localparam bit ASC = ((LO & K) == 0);
      if (ASC) begin : g_up
        usort_cas i_cas (
          .a_bit (wire_q[s][LO]),
          .b_bit (wire_q[s][HI]),
          .lo_bit(wire_q[s+1][LO]),
          .hi_bit(wire_q[s+1][HI])
        );
      end else begin : g_down
        usort_cas i_cas (
          .a_bit (wire_q[s][LO]),
          .b_bit (wire_q[s][HI]),
          .lo_bit(wire_q[s+1][HI]),
          .hi_bit(wire_q[s+1][LO])
        );
      end
    end
  end

  assign out_bits = wire_q[STAGES];
endmodule

// File: rtl/usort_ctrl.sv
module usort_ctrl #(
  parameter int VAL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             load,
  output logic             busy,
  output logic [VAL_W-1:0] idx,
  output logic             done
);
  logic             busy_q, busy_d;
  logic [VAL_W-1:0] idx_q, idx_d;
  logic             done_q, done_d;
  logic             last;

  assign load = start & ~busy_q;
  assign last = busy_q & (idx_q == {VAL_W{1'b1}});

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    done_d = 1'b0;
    if (load) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (busy_q) begin
      idx_d = idx_q + 1'b1;
      if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      done_q <= done_d;
    end
  end

  assign busy = busy_q;
  assign idx  = idx_q;
  assign done = done_q;
endmodule

// File: rtl/usort_decoder.sv
module usort_decoder #(
  parameter int VAL_W = 4,
  parameter int LANES = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic                        acc_en,
  input  logic [LANES-1:0]            bits,
  output logic [LANES-1:0][VAL_W-1:0] counts
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [VAL_W-1:0] cnt_q, cnt_d;

    always_comb begin
      cnt_d = cnt_q;
      if (clr) begin
        cnt_d = '0;
      end else if (acc_en && bits[l]) begin
        cnt_d = cnt_q + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_d;
      end
    end

    assign counts[l] = cnt_q;
  end
endmodule

// File: rtl/usort_top.sv
module usort_top #(
  parameter int VAL_W     = 4,
  parameter int LOG_LANES = 3
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   start,
  input  logic [(1<<LOG_LANES)-1:0][VAL_W-1:0]   in_vals,
  output logic [(1<<LOG_LANES)-1:0][VAL_W-1:0]   out_vals,
  output logic                                   done
);
  localparam int LANES = 1 << LOG_LANES;

  logic                        load;
  logic                        busy_q;
  logic [VAL_W-1:0]            idx_q;
  logic [LANES-1:0][VAL_W-1:0] val_q, val_d;
  logic [LANES-1:0]            enc_bits;
  logic [LANES-1:0]            net_bits;

  always_comb begin
    val_d = val_q;
    if (load) val_d = in_vals;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
    end else begin
      val_q <= val_d;
    end
  end

  usort_ctrl #(.VAL_W(VAL_W)) i_ctrl (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start),
    .load (load),
    .busy (busy_q),
    .idx  (idx_q),
    .done (done)
  );

  usort_encoder #(.VAL_W(VAL_W), .LANES(LANES)) i_enc (
    .vals(val_q),
    .idx (idx_q),
    .bits(enc_bits)
  );

  usort_net #(.LOG_LANES(LOG_LANES)) i_net (
    .in_bits (enc_bits),
    .out_bits(net_bits)
  );

  usort_decoder #(.VAL_W(VAL_W), .LANES(LANES)) i_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (load),
    .acc_en(busy_q),
    .bits  (net_bits),
    .counts(out_vals)
  );
endmodule

// File: rtl/usort_checks.sv
module usort_checks #(
  parameter int VAL_W = 4,
  parameter int LANES = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        start,
  input logic                        busy_q,
  input logic [VAL_W-1:0]            idx_q,
  input logic [LANES-1:0][VAL_W-1:0] val_q,
  input logic [LANES-1:0]            enc_bits,
  input logic [LANES-1:0]            net_bits,
  input logic [LANES-1:0][VAL_W-1:0] out_vals,
  input logic                        done
);
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy_q) && ($past(idx_q) == {VAL_W{1'b1}})));

  p_capture_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(val_q));

  p_ones_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> ($countones(enc_bits) == $countones(net_bits)));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start) |=> $stable(out_vals));

  for (genvar l = 0; l < LANES - 1; l++) begin : g_order
    p_lane_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> !(net_bits[l] && !net_bits[l+1]));
  end

  for (genvar l = 0; l < LANES; l++) begin : g_shape
    p_unary_shape_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !enc_bits[l] && (idx_q != {VAL_W{1'b1}})) |=> !enc_bits[l]);
  end
endmodule

bind usort_top usort_checks #(.VAL_W(VAL_W), .LANES(1 << LOG_LANES)) i_usort_checks (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy_q  (busy_q),
  .idx_q   (idx_q),
  .val_q   (val_q),
  .enc_bits(enc_bits),
  .net_bits(net_bits),
  .out_vals(out_vals),
  .done    (done)
);

// File: tb/test_usort_top.sv
module test_usort_top;
  localparam int VAL_W = 4;
  localparam int LOG_LANES = 3;
  localparam int LANES = 1 << LOG_LANES;
  localparam int L = 1 << VAL_W;

  logic clk, rst_n, start, done;
  logic [LANES-1:0][VAL_W-1:0] in_vals, out_vals;

  int n_chk, n_fail;
  bit finished;

  // reference model state
  int m_sorted[LANES];
  int m_t;
  bit m_busy, m_done;
  int q[$];

  usort_top #(.VAL_W(VAL_W), .LOG_LANES(LOG_LANES)) i_usort_top (
    .clk(clk), .rst_n(rst_n), .start(start),
    .in_vals(in_vals), .out_vals(out_vals), .done(done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference: running count of lane i is min(sorted[i], elapsed)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_t = 0;
      for (int l = 0; l < LANES; l++) m_sorted[l] = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_t++;
        if (m_t == L) begin m_busy = 0; m_done = 1; end
      end else if (start) begin
        q.delete();
        for (int l = 0; l < LANES; l++) q.push_back(int'(in_vals[l]));
        q.sort();
        for (int l = 0; l < LANES; l++) m_sorted[l] = q[l];
        m_busy = 1; m_t = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      for (int l = 0; l < LANES; l++) begin
        int e;
        e = (m_sorted[l] < m_t) ? m_sorted[l] : m_t;
        check(int'(out_vals[l]) == e, "R1 R2 R3 running count", int'(out_vals[l]), e);
      end
      check(done == m_done, "R5 done vs model", int'(done), int'(m_done));
    end
  end

  task automatic load_vals(input int v[LANES]);
    for (int l = 0; l < LANES; l++) in_vals[l] = v[l][VAL_W-1:0];
  endtask

  // pulse start, wait for done, check timing, final order and sums
  task automatic run_sort(input int v[LANES], input string req);
    int cyc, sum_in, sum_out;
    int s[$];
    @(negedge clk);
    load_vals(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 4 * L) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc - 1 == L, "R5 edges from capture to done", cyc - 1, L);
    sum_in = 0; sum_out = 0;
    for (int l = 0; l < LANES; l++) s.push_back(v[l]);
    s.sort();
    for (int l = 0; l < LANES; l++) begin
      check(int'(out_vals[l]) == s[l], req, int'(out_vals[l]), s[l]);
      sum_in += v[l];
      sum_out += int'(out_vals[l]);
    end
    check(sum_in == sum_out, "R8 ones preserved", sum_out, sum_in);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : stim
    int v[LANES];
    int a[LANES];
    int dones, cyc;
    n_chk = 0; n_fail = 0; finished = 0;
    rst_n = 1'b0; start = 1'b0; in_vals = '0;
    repeat (3) @(negedge clk);
    check(out_vals == '0, "R7 reset outputs", int'(out_vals[0]), 0);
    check(done == 1'b0, "R7 reset done", int'(done), 0);
    rst_n = 1'b1;

    // descending input
    for (int l = 0; l < LANES; l++) v[l] = LANES - 1 - l;
    run_sort(v, "R3 descending");
    // scattered
    v = '{9, 2, 14, 5, 11, 0, 7, 3};
    run_sort(v, "R3 scattered");
    // duplicates and extremes
    v = '{15, 0, 15, 0, 7, 7, 15, 0};
    run_sort(v, "R4 duplicates and extremes");
    v = '{15, 15, 15, 15, 15, 15, 15, 15};
    run_sort(v, "R4 all maximum");
    v = '{0, 0, 0, 0, 0, 0, 0, 0};
    run_sort(v, "R4 all zero");
    v = '{6, 6, 6, 1, 6, 6, 6, 6};
    run_sort(v, "R4 one distinct among equals");
    // random patterns
    for (int r = 0; r < 6; r++) begin
      for (int l = 0; l < LANES; l++) v[l] = int'($urandom_range(0, L - 1));
      run_sort(v, "R3 random");
    end

    // R6: a second start with new inputs during a running sort
    a = '{3, 12, 1, 8, 8, 0, 15, 4};
    @(negedge clk);
    load_vals(a);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    v = '{1, 1, 1, 1, 1, 1, 1, 1};
    load_vals(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    in_vals = '1;
    dones = 0; cyc = 6;
    while (!done && cyc < 4 * L) begin @(negedge clk); cyc++; end
    check(cyc - 1 == L, "R6 done timing unchanged", cyc - 1, L);
    q.delete();
    for (int l = 0; l < LANES; l++) q.push_back(a[l]);
    q.sort();
    for (int l = 0; l < LANES; l++)
      check(int'(out_vals[l]) == q[l], "R6 results from first capture", int'(out_vals[l]), q[l]);
    repeat (2 * L) begin @(negedge clk); if (done) dones++; end
    check(dones == 0, "R6 no second done", dones, 0);

    // R7: idle hold with changing inputs
    for (int k = 0; k < 10; k++) begin
      in_vals[k % LANES] = VAL_W'(k);
      @(negedge clk);
      for (int l = 0; l < LANES; l++)
        check(int'(out_vals[l]) == q[l], "R7 idle hold", int'(out_vals[l]), q[l]);
    end

    // start on the done cycle is accepted (back to back)
    v = '{4, 10, 2, 13, 2, 9, 0, 6};
    load_vals(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 4 * L) begin @(negedge clk); cyc++; end
    a = '{11, 5, 5, 14, 1, 3, 12, 8};
    load_vals(a);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(out_vals == '0, "R7 clear on accepted start", int'(out_vals[0]), 0);
    cyc = 1;
    while (!done && cyc < 4 * L) begin @(negedge clk); cyc++; end
    check(cyc - 1 == L, "R5 back-to-back timing", cyc - 1, L);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule